// File: doc/BRIEF.md
# Program Bank Mapper

This block turns a CPU address into a physical bank number for a cartridge-style memory system. The upper 32 KB of the CPU space (8000h–FFFFh) is cut into windows whose sizes depend on a 2-bit layout mode. Each window takes its bank number from one of four 8-bit bank registers. The top bit of that register decides whether work RAM or ROM answers the access. A separate 3-bit register picks the work-RAM bank seen in the 6000h–7FFFh window.

The CPU loads the registers through a small write port: a 3-bit register index, an 8-bit value and a strobe. The mapping itself is purely combinational from the registered state and the address. The outputs are always an 8 KB bank number: a ROM bank, a RAM bank, and a flag that says which storage answers. Software that sees a 16 KB or 32 KB window therefore gets consecutive 8 KB banks, with the low bits taken from the address.

Top module: `prg_bank_map`

## Requirements
- R1: A write with `wr_en` high stores `wr_data` at the next rising edge. Index 0 to 3 loads bank register 0 to 3 with all 8 bits: bit 7 = 1 means ROM, bit 7 = 0 means RAM, and bits 6:0 hold the bank. Index 4 loads the mode from bits 1:0. Index 5 loads the RAM-window bank from bits 2:0. Indices 6 and 7 change nothing.
- R2: After reset the mode is 3, bank register 3 holds FFh, bank registers 0 to 2 hold 80h (ROM bank 0), and the RAM-window bank is 0.
- R3: In mode 0 the whole 8000h–FFFFh range is ROM. `rom_bank` = ((reg3[6:0] >> 2) << 2) | addr[14:13].
- R4: In mode 1, 8000h–BFFFh uses b = reg1[6:0] >> 1 and C000h–FFFFh uses reg3[6:0] >> 1. A ROM 16 KB window gives `rom_bank` = (b << 1) | addr[13].
- R5: A 16 KB window that maps RAM (register bit 7 = 0) gives `ram_bank` = ((b << 1) & 7) | addr[13].
- R6: In mode 2, 8000h–BFFFh is a 16 KB window from reg1 (as in R4/R5). C000h–DFFFh is an 8 KB window from reg2. E000h–FFFFh is an 8 KB ROM window from reg3.
- R7: In mode 3, each 8 KB quarter n (n = addr[14:13]) uses register n. A RAM quarter gives `ram_bank` = reg[2:0]. A ROM quarter gives `rom_bank` = reg[6:0].
- R8: The top window (the one holding FFFFh) is ROM in every mode, even when bit 7 of register 3 is 0.
- R9: Addresses 6000h–7FFFh give `ram_sel` = 1 and `ram_bank` = the RAM-window register.
- R10: Addresses below 6000h give `ram_sel` = 0, `rom_bank` = 0 and `ram_bank` = 0.
- R11: `rom_bank` is masked to its low ROM_LOG2 bits (default 6, so 64 banks).
- R12: When `ram_sel` = 1, `rom_bank` is 0. When `ram_sel` = 0, `ram_bank` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register index |
| wr_data | input | 8 | Value to write |
| cpu_addr | input | 16 | CPU address to translate |
| rom_bank | output | 7 | 8 KB ROM bank number |
| ram_bank | output | 3 | 8 KB work-RAM bank number |
| ram_sel | output | 1 | 1 when work RAM answers the access |

## Verification
The embedded assertions check on every cycle the properties that hold whatever the register contents are:
- the top window never selects RAM;
- the 6000h–7FFFh window always selects RAM;
- low addresses select nothing;
- the ROM bank stays within the configured size;
- mode writes land on the next edge;
- writes to unused indices leave the state untouched.

The actual bank arithmetic can only be shown by the bench's scenarios. These cover each mode's window split, the shift and RAM wrap of 16 KB windows, the reset layout, and the masking of high bank numbers. The bench compares each probe with values computed from the requirements.

// File: rtl/prg_map_pkg.sv
package prg_map_pkg;
    localparam int DATA_W   = 8;
    localparam int NUM_REGS = 4;

    typedef enum logic [1:0] {
        LAYOUT_32K    = 2'd0,
        LAYOUT_16_16  = 2'd1,
        LAYOUT_16_8_8 = 2'd2,
        LAYOUT_8X4    = 2'd3
    } layout_e;
endpackage

// File: rtl/prg_map_regs.sv
module prg_map_regs
    import prg_map_pkg::*;
#(
    parameter int RAM_W = 3
) (
    input  logic                                clk,
    input  logic                                rst_n,
    input  logic                                wr_en,
    input  logic [2:0]                          wr_addr,
    input  logic [DATA_W-1:0]                   wr_data,
    output layout_e                             layout,
    output logic [NUM_REGS-1:0][DATA_W-1:0]     bank_regs,
    output logic [RAM_W-1:0]                    win_bank
);
    typedef struct packed {
        layout_e                            layout;
        logic [NUM_REGS-1:0][DATA_W-1:0]    bank;
        logic [RAM_W-1:0]                   win;
    } state_t;

    state_t state_d, state_q;

    always_comb begin
        state_d = state_q;
        if (wr_en) begin
            if (!wr_addr[2]) begin
                state_d.bank[wr_addr[1:0]] = wr_data;
            end else if (wr_addr[1:0] == 2'd0) begin
                state_d.layout = layout_e'(wr_data[1:0]);
            end else if (wr_addr[1:0] == 2'd1) begin
                state_d.win = wr_data[RAM_W-1:0];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q.layout <= LAYOUT_8X4;
            state_q.win    <= '0;
            for (int i = 0; i < NUM_REGS - 1; i++) begin
                state_q.bank[i] <= 8'h80;
            end
            state_q.bank[NUM_REGS-1] <= '1;
        end else begin
            state_q <= state_d;
        end
    end

    assign layout    = state_q.layout;
    assign bank_regs = state_q.bank;
    assign win_bank  = state_q.win;

    // R1
    mode_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == 3'd4) |=> (layout == layout_e'($past(wr_data[1:0]))));

    // R1
    unused_index_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr[2:1] == 2'b11) |=> $stable(state_q));
endmodule

// File: rtl/prg_map_decode.sv
module prg_map_decode
    import prg_map_pkg::*;
#(
    parameter int RAM_W    = 3,
    parameter int ROM_LOG2 = 6
) (
    input  layout_e                             layout,
    input  logic [NUM_REGS-1:0][DATA_W-1:0]     bank_regs,
    input  logic [RAM_W-1:0]                    win_bank,
    input  logic [2:0]                          addr_hi,
    output logic [DATA_W-2:0]                   rom_bank,
    output logic [RAM_W-1:0]                    ram_bank,
    output logic                                ram_sel
);
    localparam int BANK_W = DATA_W - 1;
    localparam logic [BANK_W-1:0] ROM_MASK = BANK_W'((1 << ROM_LOG2) - 1);

    logic [BANK_W-1:0] rom_raw;
    logic [1:0]        quarter;
    logic [DATA_W-1:0] r1, r2, r3;
    logic              unused_top_flag;

    assign quarter         = addr_hi[1:0];
    assign r1              = bank_regs[1];
    assign r2              = bank_regs[2];
    assign r3              = bank_regs[3];
    assign unused_top_flag = r3[DATA_W-1];

    always_comb begin
        rom_raw  = '0;
        ram_bank = '0;
        ram_sel  = 1'b0;
        if (addr_hi[2]) begin
            unique case (layout)
                LAYOUT_32K: begin
                    rom_raw = {r3[BANK_W-1:2], quarter};
                end
                LAYOUT_16_16: begin
                    if (!quarter[1]) begin
                        if (!r1[DATA_W-1]) begin
                            ram_sel  = 1'b1;
                            ram_bank = {r1[RAM_W-1:1], quarter[0]};
                        end else begin
                            rom_raw = {r1[BANK_W-1:1], quarter[0]};
                        end
                    end else begin
                        rom_raw = {r3[BANK_W-1:1], quarter[0]};
                    end
                end
                LAYOUT_16_8_8: begin
                    if (!quarter[1]) begin
                        if (!r1[DATA_W-1]) begin
                            ram_sel  = 1'b1;
                            ram_bank = {r1[RAM_W-1:1], quarter[0]};
                        end else begin
                            rom_raw = {r1[BANK_W-1:1], quarter[0]};
                        end
                    end else if (!quarter[0]) begin
                        if (!r2[DATA_W-1]) begin
                            ram_sel  = 1'b1;
                            ram_bank = r2[RAM_W-1:0];
                        end else begin
                            rom_raw = r2[BANK_W-1:0];
                        end
                    end else begin
                        rom_raw = r3[BANK_W-1:0];
                    end
                end
                default: begin
                    if (quarter == 2'd3) begin
                        rom_raw = r3[BANK_W-1:0];
                    end else if (!bank_regs[quarter][DATA_W-1]) begin
                        ram_sel  = 1'b1;
                        ram_bank = bank_regs[quarter][RAM_W-1:0];
                    end else begin
                        rom_raw = bank_regs[quarter][BANK_W-1:0];
                    end
                end
            endcase
        end else if (addr_hi[1:0] == 2'b11) begin
            ram_sel  = 1'b1;
            ram_bank = win_bank;
        end
    end

    assign rom_bank = rom_raw & ROM_MASK;
endmodule

// File: rtl/prg_bank_map.sv
module prg_bank_map
    import prg_map_pkg::*;
#(
    parameter int RAM_W    = 3,
    parameter int ROM_LOG2 = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [2:0]        wr_addr,
    input  logic [7:0]        wr_data,
    input  logic [15:0]       cpu_addr,
    output logic [6:0]        rom_bank,
    output logic [RAM_W-1:0]  ram_bank,
    output logic              ram_sel
);
    layout_e                         layout;
    logic [NUM_REGS-1:0][DATA_W-1:0] bank_regs;
    logic [RAM_W-1:0]                win_bank;
    logic                            unused_addr_low;

    assign unused_addr_low = ^cpu_addr[12:0];

    prg_map_regs #(.RAM_W(RAM_W)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .layout    (layout),
        .bank_regs (bank_regs),
        .win_bank  (win_bank)
    );

    prg_map_decode #(.RAM_W(RAM_W), .ROM_LOG2(ROM_LOG2)) u_decode (
        .layout    (layout),
        .bank_regs (bank_regs),
        .win_bank  (win_bank),
        .addr_hi   (cpu_addr[15:13]),
        .rom_bank  (rom_bank),
        .ram_bank  (ram_bank),
        .ram_sel   (ram_sel)
    );

    // R8
    top_window_rom_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_addr[15:13] == 3'b111) |-> !ram_sel);

    // R9
    ram_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_addr[15:13] == 3'b011) |-> (ram_sel && ram_bank == win_bank));

    // R10
    low_space_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_addr[15:13] < 3'b011) |-> (!ram_sel && rom_bank == '0 && ram_bank == '0));

    // R3
    single_window_rom_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (layout == LAYOUT_32K && cpu_addr[15]) |-> !ram_sel);

    // R11
    rom_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        32'(rom_bank) < (32'd1 << ROM_LOG2));

    // R12
    exclusive_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ram_sel ? (rom_bank == '0) : (ram_bank == '0));
endmodule

// File: tb/prg_bank_map_bench.sv
module prg_bank_map_bench;
    localparam int ROM_LOG2 = 6;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_addr = '0;
    logic [7:0]  wr_data = '0;
    logic [15:0] cpu_addr = '0;
    logic [6:0]  rom_bank;
    logic [2:0]  ram_bank;
    logic        ram_sel;

    always #5 clk = ~clk;

    prg_bank_map #(.RAM_W(3), .ROM_LOG2(ROM_LOG2)) u_prg_bank_map (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .cpu_addr (cpu_addr),
        .rom_bank (rom_bank),
        .ram_bank (ram_bank),
        .ram_sel  (ram_sel)
    );

    typedef struct {
        logic [15:0] addr;
        bit          sel;
        int          rom;
        int          ram;
        string       tag;
    } item_t;

    item_t sb[$];
    int n_checks = 0;
    int n_fail = 0;
    bit done = 1'b0;

    int m_mode;
    int m_bank[4];
    int m_win;

    // Monitor: pops and compares in the middle of each probe cycle
    always @(negedge clk) begin
        if (sb.size() != 0) begin
            item_t it;
            it = sb.pop_front();
            n_checks++;
            if (ram_sel !== it.sel || int'(rom_bank) != it.rom || int'(ram_bank) != it.ram) begin
                n_fail++;
                $display("FAIL %s addr=%h actual sel=%0d rom=%0d ram=%0d expected sel=%0d rom=%0d ram=%0d",
                         it.tag, it.addr, ram_sel, rom_bank, ram_bank, it.sel, it.rom, it.ram);
            end
        end
    end

    function automatic item_t model(input logic [15:0] a, input string tag);
        item_t e;
        int q, a13, b;
        e.addr = a; e.sel = 0; e.rom = 0; e.ram = 0; e.tag = tag;
        q = int'(a[14:13]);
        a13 = int'(a[13]);
        if (a[15]) begin
            if (m_mode == 0) begin
                e.rom = (((m_bank[3] & 127) >> 2) << 2) | q;
            end else if ((m_mode == 1 || m_mode == 2) && q < 2) begin
                b = (m_bank[1] & 127) >> 1;
                if ((m_bank[1] & 128) == 0) begin
                    e.sel = 1; e.ram = ((b << 1) & 7) | a13;
                end else begin
                    e.rom = (b << 1) | a13;
                end
            end else if (m_mode == 1) begin
                e.rom = (((m_bank[3] & 127) >> 1) << 1) | a13;
            end else if (q == 3) begin
                e.rom = m_bank[3] & 127;
            end else begin
                b = m_bank[q];
                if ((b & 128) == 0) begin
                    e.sel = 1; e.ram = b & 7;
                end else begin
                    e.rom = b & 127;
                end
            end
        end else if (a[14:13] == 2'b11) begin
            e.sel = 1; e.ram = m_win;
        end
        e.rom = e.rom & ((1 << ROM_LOG2) - 1);
        return e;
    endfunction

    task automatic probe(input logic [15:0] a, input string tag);
        @(posedge clk);
        #1;
        cpu_addr = a;
        sb.push_back(model(a, tag));
    endtask

    task automatic probe_top(input string tag);
        probe(16'h8000, tag);
        probe(16'hA123, tag);
        probe(16'hC456, tag);
        probe(16'hFFFC, tag);
    endtask

    task automatic wr(input logic [2:0] idx, input logic [7:0] d);
        @(posedge clk);
        #1;
        wr_en = 1'b1; wr_addr = idx; wr_data = d;
        @(posedge clk);
        #1;
        wr_en = 1'b0;
        if (idx < 4) m_bank[idx] = int'(d);
        else if (idx == 4) m_mode = int'(d[1:0]);
        else if (idx == 5) m_win = int'(d[2:0]);
    endtask

    initial begin
        #(200000 * 10);
        if (!done) begin
            n_fail++;
            n_checks++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        // R2 reset state
        m_mode = 3; m_bank[0] = 'h80; m_bank[1] = 'h80; m_bank[2] = 'h80; m_bank[3] = 'hFF; m_win = 0;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        probe_top("R2 reset layout");
        probe(16'h6000, "R2 reset window");
        probe(16'h1234, "R10 low space");
        probe(16'h5FFF, "R10 low space");

        // R7 mode 3 mixed RAM/ROM quarters
        wr(3'd0, 8'h05);
        wr(3'd1, 8'h8A);
        wr(3'd2, 8'h13);
        wr(3'd3, 8'h04);
        probe_top("R7 8k quarters / R8 top forced ROM");

        // R1 unused indices change nothing
        wr(3'd6, 8'h00);
        wr(3'd7, 8'hFF);
        probe_top("R1 ignored index");
        probe(16'h7000, "R1 ignored index window");

        // R9 RAM window register
        wr(3'd5, 8'hFE);
        probe(16'h6ABC, "R9 ram window");
        probe(16'h7FFF, "R9 ram window");

        // R3 mode 0
        wr(3'd4, 8'hFC);
        wr(3'd3, 8'h07);
        probe_top("R3 single 32k window");
        wr(3'd3, 8'h7D);
        probe_top("R11 rom mask in 32k");

        // R4/R5 mode 1
        wr(3'd4, 8'h01);
        wr(3'd1, 8'h06);
        wr(3'd3, 8'h0B);
        probe_top("R5 16k RAM window / R4 upper");
        wr(3'd1, 8'h8E);
        wr(3'd3, 8'hF3);
        probe_top("R4 16k ROM windows / R11");
        wr(3'd1, 8'h7F);
        probe_top("R5 16k RAM wrap");

        // R6 mode 2
        wr(3'd4, 8'h02);
        wr(3'd1, 8'hA4);
        wr(3'd2, 8'h1E);
        wr(3'd3, 8'h22);
        probe_top("R6 16/8/8 layout RAM middle");
        wr(3'd2, 8'hC9);
        probe_top("R6 16/8/8 layout ROM middle");
        probe(16'h0000, "R12 no output in low space");

        // R7 mode 3 all RAM below top
        wr(3'd4, 8'h03);
        wr(3'd0, 8'h7F);
        wr(3'd1, 8'h02);
        wr(3'd2, 8'h00);
        probe_top("R7 8k RAM low bits / R12");

        repeat (3) @(posedge clk);
        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule